// File: doc/BRIEF.md
# Rank-Ordered Deterministic FP32 Reducer

This block reduces one lane of a collective sum. Participants deliver single-precision values over a valid/ready input. Each value carries the participant's rank index and an epoch tag, and values may arrive in any order. The block parks each value in a slot chosen by its rank and records the arrival in a bitmap of seen ranks. The result stays withheld until every rank named in the expected-rank mask has delivered.

Once the bitmap covers the mask, a sequencer walks the slots from rank 0 upward. Slots whose rank is outside the mask are skipped. Each value is added into a running total by a rounding FP32 adder, one addition per cycle. The total then appears on a valid/ready output together with the epoch tag. Because the order of addition depends only on rank numbers, the output bit pattern cannot depend on arrival timing. The result is repeatable, but it is not exact, because it is rounded after each step. Only one epoch is open at a time. The bitmap is wiped when the result is taken, which opens the next epoch.

Top module: `ordered_fp32_reducer`

## Requirements
- R1: After reset, `out_valid` and `drop_err` are 0 and `in_ready` is 1.
- R2: `out_valid` stays 0 until every rank whose bit is set in `exp_mask` has had a value accepted. An all-zero mask never produces a result.
- R3: The result equals the sequence t = -0, then t = t + v[r] for each masked rank r in ascending order. Each addition is an IEEE binary32 add with round-to-nearest-even.
- R4: Delivering the same ranks and values in any arrival order gives the identical 32-bit result.
- R5: If any operand is a NaN, the result is 0x7FC00000. A sum of +infinity and -infinity also gives 0x7FC00000.
- R6: A value for a rank already marked in the bitmap is consumed and discarded, and `drop_err` is 1 in the following cycle. The stored value for that rank is unchanged.
- R7: A value whose rank bit is 0 in `exp_mask` is consumed and discarded, and `drop_err` is 1 in the following cycle.
- R8: `in_ready` is 0 from the cycle after the bitmap becomes complete until the result is taken. Once an epoch has a value stored, `in_ready` is also 0 for any offer whose epoch tag differs from the open epoch.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_epoch` hold steady. After the handshake, the bitmap is empty and `in_ready` returns to 1.
- R10: `out_epoch` equals the epoch tag of the contributions that formed the result.
- R11: The adder handles subnormal operands and results exactly as IEEE binary32 does, breaks rounding ties to even, and gives a signed infinity on overflow. An exact cancellation gives +0, and -0 plus -0 gives -0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| exp_mask | input | 16 | Expected ranks, bit r set means rank r must contribute |
| in_valid | input | 1 | Contribution offered |
| in_ready | output | 1 | Contribution can be taken |
| in_rank | input | 4 | Rank index of the contribution |
| in_epoch | input | 8 | Epoch tag of the contribution |
| in_data | input | 32 | FP32 value of the contribution |
| out_valid | output | 1 | Reduced result available |
| out_ready | input | 1 | Consumer takes the result |
| out_epoch | output | 8 | Epoch tag of the result |
| out_data | output | 32 | Reduced FP32 result |
| drop_err | output | 1 | One-cycle pulse: the previously taken contribution was discarded |

## Verification
The stimulus vectors feed the same operands in reversed and shuffled arrival orders. Two of the vectors are built so that summing in arrival order rounds differently from summing in rank order. A design that added values as they arrived would give 0x3F800000 where 0x3F800001 is due. A repeated rank carries a much larger value, so a design that overwrote the slot would give a result far from 10.0. The tests also use a sparse mask with gaps, a value from a rank outside the mask, an empty mask, and an offer tagged with a foreign epoch. A design that included a skipped rank, emitted too early or took a foreign epoch would change the output or raise `in_ready` when it must not. Further vectors cover canonical NaN, infinity cancellation, overflow, signed zeros, subnormal sums and an upward tie-to-even.

// File: rtl/fp_red_pkg.sv
package fp_red_pkg;
  localparam int FP_W = 32;
  localparam logic [FP_W-1:0] FP_QNAN     = 32'h7FC0_0000;
  localparam logic [FP_W-1:0] FP_NEG_ZERO = 32'h8000_0000;

  typedef enum logic [1:0] {
    ST_COLLECT = 2'd0,
    ST_SUM     = 2'd1,
    ST_EMIT    = 2'd2
  } red_state_e;
endpackage

// File: rtl/fp32_add_rne.sv
module fp32_add_rne
  import fp_red_pkg::*;
(
  input  logic [FP_W-1:0] a_i,
  input  logic [FP_W-1:0] b_i,
  output logic [FP_W-1:0] sum_o
);
  function automatic logic [4:0] clz27(input logic [26:0] v);
    logic [4:0] n;
    n = 5'd27;
    for (int i = 0; i < 27; i++) if (v[i]) n = 5'(26 - i);
    return n;
  endfunction

  logic        a_nan, b_nan, a_inf, b_inf, swap, eff_sub, zero_sum, g, st, up;
  logic [31:0] x, y;
  logic [9:0]  ex, ey, e, d, sh;
  logic [26:0] mx, my, my_sh, lost;
  logic [27:0] s;
  logic [4:0]  lz;
  logic [24:0] mr;
  logic [23:0] m;

  always_comb begin
    a_nan = (&a_i[30:23]) & (|a_i[22:0]);
    b_nan = (&b_i[30:23]) & (|b_i[22:0]);
    a_inf = (&a_i[30:23]) & ~(|a_i[22:0]);
    b_inf = (&b_i[30:23]) & ~(|b_i[22:0]);
    // order operands by magnitude
    swap = b_i[30:0] > a_i[30:0];
    x = swap ? b_i : a_i;
    y = swap ? a_i : b_i;
    ex = (x[30:23] == 8'd0) ? 10'd1 : {2'b00, x[30:23]};
    ey = (y[30:23] == 8'd0) ? 10'd1 : {2'b00, y[30:23]};
    mx = {x[30:23] != 8'd0, x[22:0], 3'b000};
    my = {y[30:23] != 8'd0, y[22:0], 3'b000};
    d  = ex - ey;
    lost = '0;
    if (d > 10'd26) begin
      my_sh = {26'd0, |my};
    end else begin
      lost  = ~(27'h7FF_FFFF << d);
      my_sh = my >> d;
      my_sh[0] = my_sh[0] | (|(my & lost));
    end
    eff_sub = x[31] ^ y[31];
    s = eff_sub ? ({1'b0, mx} - {1'b0, my_sh}) : ({1'b0, mx} + {1'b0, my_sh});
    zero_sum = (s == 28'd0);
    e  = ex;
    lz = 5'd0;
    sh = 10'd0;
    if (s[27]) begin
      s = {1'b0, s[27:2], s[1] | s[0]};
      e = e + 10'd1;
    end else begin
      lz = clz27(s[26:0]);
      sh = ({5'd0, lz} > (e - 10'd1)) ? (e - 10'd1) : {5'd0, lz};
      s  = s << sh;
      e  = e - sh;
    end
    // round to nearest, ties to even
    g  = s[2];
    st = |s[1:0];
    up = g & (st | s[3]);
    mr = {1'b0, s[26:3]} + {24'd0, up};
    if (mr[24]) begin
      m = mr[24:1];
      e = e + 10'd1;
    end else begin
      m = mr[23:0];
    end
    if (e >= 10'd255) sum_o = {x[31], 8'hFF, 23'd0};
    else              sum_o = {x[31], (m[23] ? e[7:0] : 8'd0), m[22:0]};
    if (zero_sum) sum_o = {x[31] & y[31], 31'd0};
    if (a_nan | b_nan | (a_inf & b_inf & (a_i[31] ^ b_i[31]))) sum_o = FP_QNAN;
    else if (a_inf) sum_o = a_i;
    else if (b_inf) sum_o = b_i;
  end
endmodule

// File: rtl/fp_rank_store.sv
module fp_rank_store #(
  parameter int N_SLOTS = 16,
  parameter int DATA_W  = 32,
  parameter int IDX_W   = $clog2(N_SLOTS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               clr,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [N_SLOTS-1:0] seen_o,
  output logic [DATA_W-1:0]  rd_data_o
);
  logic [N_SLOTS-1:0] seen_q, seen_d;
  logic [DATA_W-1:0]  slots [N_SLOTS];

  always_comb begin
    seen_d = seen_q;
    if (clr)        seen_d = '0;
    else if (wr_en) seen_d[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= '0;
    else        seen_q <= seen_d;
  end

  for (genvar gi = 0; gi < N_SLOTS; gi++) begin : g_slot
    logic slot_ce;
    logic [DATA_W-1:0] slot_q;
    assign slot_ce = wr_en && (wr_idx == IDX_W'(gi));
    always_ff @(posedge clk) begin
      if (slot_ce) slot_q <= wr_data;
    end
    assign slots[gi] = slot_q;
  end

  assign seen_o    = seen_q;
  assign rd_data_o = slots[rd_idx];
endmodule

// File: rtl/ordered_fp32_reducer.sv
module ordered_fp32_reducer
  import fp_red_pkg::*;
#(
  parameter int N_RANKS = 16,
  parameter int EPOCH_W = 8,
  parameter int RANK_W  = $clog2(N_RANKS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_RANKS-1:0] exp_mask,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [RANK_W-1:0]  in_rank,
  input  logic [EPOCH_W-1:0] in_epoch,
  input  logic [FP_W-1:0]    in_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [EPOCH_W-1:0] out_epoch,
  output logic [FP_W-1:0]    out_data,
  output logic               drop_err
);
  localparam logic [RANK_W-1:0] LAST_IDX = RANK_W'(N_RANKS - 1);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_m_q, rst_s_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  red_state_e         state_q, state_d;
  logic [RANK_W-1:0]  idx_q, idx_d;
  logic [FP_W-1:0]    acc_q, acc_d, sum_w, slot_rd;
  logic [EPOCH_W-1:0] epoch_q, epoch_d;
  logic               err_q, err_d;
  logic [N_RANKS-1:0] seen_w;
  logic               in_fire, take_ok, wr_en, complete, pop;

  assign complete  = (exp_mask != '0) && ((seen_w & exp_mask) == exp_mask);
  assign in_ready  = rst_s_q && (state_q == ST_COLLECT) && !complete &&
                     ((seen_w == '0) || (in_epoch == epoch_q));
  assign in_fire   = in_valid && in_ready;
  assign take_ok   = exp_mask[in_rank] && !seen_w[in_rank];
  assign wr_en     = in_fire && take_ok;
  assign out_valid = (state_q == ST_EMIT);
  assign pop       = out_valid && out_ready;

  fp_rank_store #(.N_SLOTS(N_RANKS), .DATA_W(FP_W), .IDX_W(RANK_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_s_q),
    .wr_en     (wr_en),
    .wr_idx    (in_rank),
    .wr_data   (in_data),
    .clr       (pop),
    .rd_idx    (idx_q),
    .seen_o    (seen_w),
    .rd_data_o (slot_rd)
  );

  fp32_add_rne u_add (
    .a_i   (acc_q),
    .b_i   (slot_rd),
    .sum_o (sum_w)
  );

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    acc_d   = acc_q;
    epoch_d = epoch_q;
    err_d   = in_fire && !take_ok;
    if (wr_en && (seen_w == '0)) epoch_d = in_epoch;
    case (state_q)
      ST_COLLECT: if (complete) begin
        state_d = ST_SUM;
        idx_d   = '0;
        acc_d   = FP_NEG_ZERO;
      end
      ST_SUM: begin
        if (exp_mask[idx_q]) acc_d = sum_w;
        idx_d = idx_q + RANK_W'(1);
        if (idx_q == LAST_IDX) state_d = ST_EMIT;
      end
      ST_EMIT: if (pop) state_d = ST_COLLECT;
      default: state_d = ST_COLLECT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_q) begin
    if (!rst_s_q) begin
      state_q <= ST_COLLECT;
      idx_q   <= '0;
      acc_q   <= FP_NEG_ZERO;
      epoch_q <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      acc_q   <= acc_d;
      epoch_q <= epoch_d;
      err_q   <= err_d;
    end
  end

  assign out_data  = acc_q;
  assign out_epoch = epoch_q;
  assign drop_err  = err_q;
endmodule

// File: rtl/ordered_fp32_reducer_chk.sv
module ordered_fp32_reducer_chk #(
  parameter int N_RANKS = 16,
  parameter int EPOCH_W = 8,
  parameter int RANK_W  = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_RANKS-1:0] exp_mask,
  input logic               in_valid,
  input logic               in_ready,
  input logic [RANK_W-1:0]  in_rank,
  input logic               out_valid,
  input logic               out_ready,
  input logic [EPOCH_W-1:0] out_epoch,
  input logic [31:0]        out_data,
  input logic               drop_err,
  input logic [N_RANKS-1:0] seen
);
  a_r2_wait_all: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (exp_mask != '0) && ((seen & exp_mask) == exp_mask));

  a_r6_dup_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && seen[in_rank]) |=> drop_err);

  a_r7_mask_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !exp_mask[in_rank]) |=> drop_err);

  a_r8_hold_ready: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  a_r9_out_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_data) && $stable(out_epoch));

  a_r9_clear_after_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (seen == '0));
endmodule

bind ordered_fp32_reducer ordered_fp32_reducer_chk #(
  .N_RANKS(N_RANKS), .EPOCH_W(EPOCH_W), .RANK_W(RANK_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .exp_mask  (exp_mask),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_rank   (in_rank),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_epoch (out_epoch),
  .out_data  (out_data),
  .drop_err  (drop_err),
  .seen      (seen_w)
);

// File: tb/ordered_fp32_reducer_bench.sv
`timescale 1ns/1ps
module ordered_fp32_reducer_bench;
  typedef struct packed {
    logic [15:0]  ranks;  // four rank nibbles, slot 0 lowest
    logic [127:0] vals;   // four FP32 values, slot 0 lowest
    logic [7:0]   order;  // arrival order: 2-bit slot numbers, first lowest
    logic [31:0]  expv;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{16'h3210, {32'h40800000, 32'h40400000, 32'h40000000, 32'h3F800000}, 8'h87, 32'h41200000},
    '{16'h3210, {32'h40800000, 32'h40400000, 32'h40000000, 32'h3F800000}, 8'hE4, 32'h41200000},
    '{16'h3210, {32'h00000000, 32'h33800000, 32'h33800000, 32'h3F800000}, 8'h1B, 32'h3F800000},
    '{16'h3210, {32'h00000000, 32'h3F800000, 32'h33800000, 32'h33800000}, 8'h72, 32'h3F800001},
    '{16'hFC73, {32'h41000000, 32'h3E800000, 32'hBF000000, 32'h3FC00000}, 8'h63, 32'h41140000},
    '{16'h9521, {32'h40400000, 32'h40000000, 32'h7F800001, 32'h3F800000}, 8'hE4, 32'h7FC00000},
    '{16'h3210, {32'h3F800000, 32'h3F800000, 32'hFF800000, 32'h7F800000}, 8'h1B, 32'h7FC00000},
    '{16'h8654, {32'h00000000, 32'h00000000, 32'h7F7FFFFF, 32'h7F7FFFFF}, 8'h87, 32'h7F800000},
    '{16'h3210, {32'h80000000, 32'h80000000, 32'hBF800000, 32'h3F800000}, 8'h72, 32'h00000000},
    '{16'h3210, {32'h007FFFFF, 32'h00000002, 32'h00000001, 32'h00000001}, 8'h1B, 32'h00800003},
    '{16'h3210, {32'h00000000, 32'h00000000, 32'h33800000, 32'h3F800001}, 8'h87, 32'h3F800002},
    '{16'hEA62, {32'h80000000, 32'h80000000, 32'h80000000, 32'h80000000}, 8'hE4, 32'h80000000}
  };

  logic        clk, rst_n;
  logic [15:0] exp_mask;
  logic        in_valid, in_ready, out_valid, out_ready, drop_err;
  logic [3:0]  in_rank;
  logic [7:0]  in_epoch, out_epoch;
  logic [31:0] in_data, out_data;
  int          checks, errors;
  logic        done;

  ordered_fp32_reducer u_ordered_fp32_reducer (
    .clk(clk), .rst_n(rst_n), .exp_mask(exp_mask),
    .in_valid(in_valid), .in_ready(in_ready), .in_rank(in_rank),
    .in_epoch(in_epoch), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_epoch(out_epoch),
    .out_data(out_data), .drop_err(drop_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic send(input logic [3:0] r, input logic [7:0] ep, input logic [31:0] v);
    @(negedge clk);
    in_valid = 1'b1; in_rank = r; in_epoch = ep; in_data = v;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic take_result(input int hold, output logic [31:0] d, output logic [7:0] ep);
    int n;
    n = 0;
    while (!out_valid && n < 200) begin
      @(negedge clk);
      n++;
    end
    check("R2 result appears", {31'd0, out_valid}, 32'd1);
    d = out_data; ep = out_epoch;
    for (int j = 0; j < hold; j++) begin
      @(negedge clk);
      check("R9 held data", out_data, d);
      check("R9 held valid", {31'd0, out_valid}, 32'd1);
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  initial begin
    done = 1'b0;
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] res;
    logic [7:0]  rep;
    string       req;
    int          sl;
    checks = 0; errors = 0;
    rst_n = 1'b0; exp_mask = 16'h000F;
    in_valid = 1'b0; in_rank = '0; in_epoch = '0; in_data = '0; out_ready = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 out_valid", {31'd0, out_valid}, 32'd0);
    check("R1 drop_err", {31'd0, drop_err}, 32'd0);
    check("R1 in_ready", {31'd0, in_ready}, 32'd1);

    // wait-all, duplicate, out-of-mask, foreign epoch, output hold
    send(4'd0, 8'h40, 32'h3F800000);
    @(negedge clk);
    in_valid = 1'b1; in_rank = 4'd2; in_epoch = 8'h41; in_data = 32'h40400000;
    #1 check("R8 foreign epoch blocked", {31'd0, in_ready}, 32'd0);
    in_valid = 1'b0;
    send(4'd1, 8'h40, 32'h40000000);
    send(4'd2, 8'h40, 32'h40400000);
    send(4'd1, 8'h40, 32'h42C80000);
    check("R6 duplicate flagged", {31'd0, drop_err}, 32'd1);
    send(4'd9, 8'h40, 32'h3F800000);
    check("R7 out-of-mask flagged", {31'd0, drop_err}, 32'd1);
    repeat (20) @(negedge clk);
    check("R2 no early result", {31'd0, out_valid}, 32'd0);
    send(4'd3, 8'h40, 32'h40800000);
    check("R8 ready low after completion", {31'd0, in_ready}, 32'd0);
    take_result(5, res, rep);
    check("R6 stored value kept", res, 32'h41200000);
    check("R10 epoch tag", {24'd0, rep}, 32'h40);
    check("R9 ready after pop", {31'd0, in_ready}, 32'd1);

    // empty mask never completes
    exp_mask = 16'h0000;
    send(4'd0, 8'h50, 32'h3F800000);
    check("R7 empty mask drop", {31'd0, drop_err}, 32'd1);
    repeat (20) @(negedge clk);
    check("R2 empty mask no result", {31'd0, out_valid}, 32'd0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      logic [15:0] m;
      m = '0;
      for (int k = 0; k < 4; k++) m[VECS[i].ranks[4*k +: 4]] = 1'b1;
      exp_mask = m;
      for (int k = 0; k < 4; k++) begin
        sl = int'(VECS[i].order[2*k +: 2]);
        send(VECS[i].ranks[4*sl +: 4], 8'(i + 16), VECS[i].vals[32*sl +: 32]);
      end
      take_result(0, res, rep);
      if (i == 1 || i == 3)      req = "R4 order independence";
      else if (i >= 5 && i <= 6) req = "R5 NaN result";
      else if (i >= 7)           req = "R11 IEEE corner";
      else                       req = "R3 ordered sum";
      check(req, res, VECS[i].expv);
      check("R10 epoch tag", {24'd0, rep}, 32'(i + 16));
    end

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule